// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block is the host side of a bit-serial configuration port. It takes a configuration image as a byte stream with a valid/ready/last handshake. It resets the target by pulling the active-low program strobe low for a set number of system clocks. It then waits for the target to release its open-drain init line and clocks the image out one bit per configuration-clock rising edge. The loader never drives the init line. It only senses it, through a two-flop synchroniser.

While the image is being shifted, a low on init means the target has found a corrupt bitstream. The loader then stops clocking and reports an error. When the done line goes high, the loader gives the target a parameterised number of further clock edges so it can finish startup. If the supplied image has already ended, those bits carry ones. Timeouts on the init release and on done raise the same error flag. A start pulse restarts the whole sequence from the idle, success or error state.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse in idle, success or error state drives `prog_n_o` low for exactly PROG_CYCLES system clocks, then releases it.
- R2: No rising edge of `cclk_o` occurs until init has been seen high after the program pulse. If init stays low for INIT_TIMEOUT clocks after release, `err_o` rises and no clock edge is issued.
- R3: Each byte is shifted most-significant bit first. `sdata_o` changes only while `cclk_o` is low, so it is stable at every rising edge and through the high phase.
- R4: `in_ready` is high only while shifting and only when the shift register is empty. It is never high while `busy_o` is low.
- R5: A low on init during shifting or startup clocking raises `err_o`, and no further `cclk_o` rising edge follows.
- R6: After done is seen high, at least POST_CLKS (two or more) further rising edges are issued before `ok_o` rises.
- R7: Once the byte marked by `in_last` has been fully shifted, every later bit on `sdata_o` is 1 while clocking continues.
- R8: If done has not gone high within DONE_TIMEOUT clocks of the start of shifting, `err_o` rises.
- R9: After reset all status outputs are low, `prog_n_o` and `sdata_o` are high and `cclk_o` is low. `busy_o` covers the whole load, and at most one of `busy_o`, `ok_o` and `err_o` is high at any time.
- R10: With data available, the `cclk_o` period is 2*CCLK_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (idle, success or error state) |
| in_data | input | DATA_W | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_last | input | 1 | Marks the final image byte |
| in_ready | output | 1 | Loader can take a byte |
| prog_n_o | output | 1 | Active-low program strobe to the target |
| cclk_o | output | 1 | Configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Open-drain init/error line (externally pulled up) |
| done_i | input | 1 | Target done line |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed |
| err_o | output | 1 | Last load failed (CRC flag or timeout) |

## Verification
The bench builds the loader with CCLK_HALF=2, PROG_CYCLES=8, INIT_TIMEOUT=60, DONE_TIMEOUT=400 and POST_CLKS=3. With these values both timeouts fire within a few hundred cycles, so the init-release timeout can be checked to the exact cycle and the done timeout reached while the loader is padding ones. A behavioural target in the bench releases init after a delay, captures bits on rising edges, and raises done or pulls init low at a chosen bit count. This covers these cases: done exactly at the end of the image, done after the image has run out, done in the middle of a byte, and a CRC failure part-way through.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_PROG  = 3'd1,
    LD_WINIT = 3'd2,
    LD_SHIFT = 3'd3,
    LD_POST  = 3'd4,
    LD_OK    = 3'd5,
    LD_ERR   = 3'd6
  } ld_state_t;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgl_bitclk.sv
// Configuration clock generator: the high phase is always CCLK_HALF system clocks.
// The low phase waits for a pending bit and an enabling gate before it rises.
module cfgl_bitclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pending,
  input  logic gate,
  output logic cclk_o,
  output logic rise_o
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          at_top;

  assign at_top = (cnt == CW'(HALF - 1));
  assign rise_o = run && !cclk_o && pending && gate && at_top;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      cclk_o <= 1'b0;
    end else if (cclk_o) begin
      if (at_top) begin
        cclk_o <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (rise_o) begin
      cclk_o <= 1'b1;
      cnt    <= '0;
    end else if (!at_top) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a rising configuration edge only follows a cycle in which init was high
  p_rise_gated_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> $past(gate));
endmodule

// File: rtl/cfgl_shifter.sv
// Byte-to-bit serialiser. Bits are loaded onto the data line during the clock's
// low phase. Ones are supplied after the last byte, or when intake is closed.
module cfgl_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              intake_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              cclk,
  input  logic              rise,
  output logic              in_ready,
  output logic              pending,
  output logic              sdata_o
);
  localparam int LW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [LW-1:0]     left;
  logic              pad;
  logic              have_bit;
  logic              load;

  assign have_bit = (left != '0) || pad || !intake_en;
  assign in_ready = run && intake_en && (left == '0) && !pad;
  assign load     = run && !cclk && !pending && have_bit;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      shreg   <= '0;
      left    <= '0;
      pad     <= 1'b0;
      pending <= 1'b0;
      sdata_o <= 1'b1;
    end else begin
      if (in_valid && in_ready) begin
        shreg <= in_data;
        left  <= LW'(DATA_W);
        pad   <= in_last;
      end
      if (load) begin
        pending <= 1'b1;
        if (left != '0) begin
          sdata_o <= shreg[DATA_W-1];
          shreg   <= {shreg[DATA_W-2:0], 1'b0};
          left    <= left - 1'b1;
        end else begin
          sdata_o <= 1'b1;
        end
      end else if (rise) begin
        pending <= 1'b0;
      end
    end
  end

  // R3: data is held through the whole high phase of the configuration clock
  p_stable_high_r3: assert property (@(posedge clk) disable iff (rst)
    (cclk && $past(cclk)) |-> $stable(sdata_o));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CCLK_HALF     = 4,
  parameter int PROG_CYCLES   = 500,
  parameter int INIT_TIMEOUT  = 50000,
  parameter int DONE_TIMEOUT  = 1000000,
  parameter int POST_CLKS     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              sdata_o,
  input  logic              init_n_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              ok_o,
  output logic              err_o
);
  localparam int T1     = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int TMAX   = (T1 > DONE_TIMEOUT) ? T1 : DONE_TIMEOUT;
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int PC_W   = $clog2(POST_CLKS + 1);

  ld_state_t        state_q;
  logic [TMR_W-1:0] tmr;
  logic [PC_W-1:0]  post_q;
  logic             init_s, done_s;
  logic             run, pending, rise;

  cfgl_sync #(.STAGES(2)) u_sync_init (.clk(clk), .rst(rst), .d(init_n_i), .q(init_s));
  cfgl_sync #(.STAGES(2)) u_sync_done (.clk(clk), .rst(rst), .d(done_i),   .q(done_s));

  assign run = (state_q == LD_SHIFT) || (state_q == LD_POST);

  cfgl_bitclk #(.HALF(CCLK_HALF)) u_bitclk (
    .clk(clk), .rst(rst), .run(run), .pending(pending), .gate(init_s),
    .cclk_o(cclk_o), .rise_o(rise)
  );

  cfgl_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .run(run), .intake_en(state_q == LD_SHIFT),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .cclk(cclk_o), .rise(rise), .in_ready(in_ready),
    .pending(pending), .sdata_o(sdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LD_IDLE;
      tmr      <= '0;
      post_q   <= '0;
      prog_n_o <= 1'b1;
    end else begin
      case (state_q)
        LD_IDLE, LD_OK, LD_ERR: begin
          if (start) begin
            state_q  <= LD_PROG;
            tmr      <= '0;
            prog_n_o <= 1'b0;
          end
        end
        LD_PROG: begin
          if (tmr == TMR_W'(PROG_CYCLES - 1)) begin
            state_q  <= LD_WINIT;
            tmr      <= '0;
            prog_n_o <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LD_WINIT: begin
          if (init_s) begin
            state_q <= LD_SHIFT;
            tmr     <= '0;
          end else if (tmr == TMR_W'(INIT_TIMEOUT - 1)) begin
            state_q <= LD_ERR;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LD_SHIFT: begin
          if (!init_s) begin
            state_q <= LD_ERR;
          end else if (done_s) begin
            state_q <= LD_POST;
            post_q  <= '0;
          end else if (tmr == TMR_W'(DONE_TIMEOUT - 1)) begin
            state_q <= LD_ERR;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LD_POST: begin
          if (!init_s) begin
            state_q <= LD_ERR;
          end else if (post_q == PC_W'(POST_CLKS) && !cclk_o) begin
            state_q <= LD_OK;
          end else if (rise && post_q != PC_W'(POST_CLKS)) begin
            post_q <= post_q + 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == LD_PROG) || (state_q == LD_WINIT) || run;
  assign ok_o   = (state_q == LD_OK);
  assign err_o  = (state_q == LD_ERR);

  // R1: the strobe is low for as long as the program phase lasts
  p_prog_low_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == LD_PROG) |-> !prog_n_o);
  // R5: a failure is held until a new start
  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start) |=> err_o);
  // R6: success is only reported with done seen high
  p_ok_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_o) |-> done_s);
  // R9: status flags are mutually exclusive
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, ok_o, err_o}));
  // R9: clock is quiet in idle and after success
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == LD_IDLE) || ok_o) |-> !cclk_o);
endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int HALF     = 2;
  localparam int PROG     = 8;
  localparam int INIT_TO  = 60;
  localparam int DONE_TO  = 400;
  localparam int POSTC    = 3;
  localparam int INIT_DLY = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready, prog_n_o, cclk_o, sdata_o, init_n_i, done_i;
  logic       busy_o, ok_o, err_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cfg_serial_loader #(
    .DATA_W(8), .CCLK_HALF(HALF), .PROG_CYCLES(PROG), .INIT_TIMEOUT(INIT_TO),
    .DONE_TIMEOUT(DONE_TO), .POST_CLKS(POSTC)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
    .sdata_o(sdata_o), .init_n_i(init_n_i), .done_i(done_i), .busy_o(busy_o),
    .ok_o(ok_o), .err_o(err_o)
  );

  // behavioural target: open-drain init with pull-up, bit capture on rising cclk
  logic         t_init_low = 1'b0;
  logic         t_done = 1'b0;
  logic         t_crc = 1'b0;
  logic         t_hold = 1'b0;
  logic         t_clr = 1'b0;
  logic         cclk_q = 1'b0;
  int           t_icnt = 0;
  int           done_at = 0;
  int           crc_at = 0;
  int           rxn = 0, rises = 0, early = 0, post_rises = 0, post_zero = 0;
  int           prog_len = 0, ready_bad = 0;
  logic [127:0] rxbits = '0;
  longint       cyc = 0, t_r0 = 0, t_r1 = 0;
  logic [7:0]   src [4];

  assign init_n_i = !t_init_low;
  assign done_i   = t_done;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    cclk_q <= cclk_o;
    if (in_ready && !busy_o) ready_bad <= ready_bad + 1;
    if (t_clr) begin
      rxn <= 0; rises <= 0; early <= 0; post_rises <= 0; post_zero <= 0;
      prog_len <= 0; rxbits <= '0;
    end else if (!prog_n_o) begin
      t_init_low <= 1'b1; t_icnt <= 0; t_done <= 1'b0; t_crc <= 1'b0;
      prog_len <= prog_len + 1;
    end else begin
      if (t_init_low && !t_crc && !t_hold) begin
        if (t_icnt == INIT_DLY) t_init_low <= 1'b0;
        else t_icnt <= t_icnt + 1;
      end
      if (cclk_o && !cclk_q) begin
        rises <= rises + 1;
        if (t_init_low && !t_crc) early <= early + 1;
        if (!t_done) begin
          if (rxn < 128) rxbits[rxn] <= sdata_o;
          if (rxn == 0) t_r0 <= cyc;
          if (rxn == 1) t_r1 <= cyc;
          rxn <= rxn + 1;
          if (rxn + 1 == done_at) t_done <= 1'b1;
          if (rxn + 1 == crc_at) begin t_init_low <= 1'b1; t_crc <= 1'b1; end
        end else begin
          post_rises <= post_rises + 1;
          if (!sdata_o) post_zero <= post_zero + 1;
        end
      end
    end
  end

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_byte(input int k);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[7-j] = rxbits[8*k+j];
    return v;
  endfunction

  int wait_n = 0;

  task automatic run_load(input int nb, input int d_at, input int c_at, input bit hold, input int maxw);
    @(negedge clk);
    done_at = d_at; crc_at = c_at; t_hold = hold; t_clr = 1'b1;
    @(negedge clk);
    t_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o && !in_ready, "R9 busy after start", busy_o, 1);
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          in_data = src[i]; in_valid = 1'b1; in_last = (i == nb - 1);
          @(negedge clk);
          while (!in_ready && !(ok_o || err_o)) @(negedge clk);
          if (ok_o || err_o) break;
          @(posedge clk);
          #1;
        end
        in_valid = 1'b0; in_last = 1'b0;
      end
      begin
        wait_n = 0;
        while (!(ok_o || err_o) && wait_n < maxw) begin
          @(negedge clk);
          wait_n++;
        end
      end
    join
  endtask

  task automatic t_reset;
    chk(!busy_o && !ok_o && !err_o, "R9 status after reset", {busy_o, ok_o, err_o}, 0);
    chk(prog_n_o && sdata_o && !cclk_o, "R9 pins after reset", {prog_n_o, sdata_o, cclk_o}, 3'b110);
    chk(!in_ready, "R4 ready after reset", in_ready, 0);
  endtask

  task automatic t_normal;
    src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'hF0;
    run_load(3, 24, 0, 1'b0, 2000);
    chk(ok_o, "R6 ok after done", ok_o, 1);
    chk(prog_len == PROG, "R1 program pulse length", prog_len, PROG);
    chk(early == 0, "R2 no edge before init release", early, 0);
    for (int k = 0; k < 3; k++)
      chk(rx_byte(k) == src[k], "R3 byte MSB first", rx_byte(k), src[k]);
    chk(t_r1 - t_r0 == 2 * HALF, "R10 cclk period", t_r1 - t_r0, 2 * HALF);
    chk(post_rises >= POSTC, "R6 startup edges", post_rises, POSTC);
    chk(post_zero == 0, "R7 pad ones after end", post_zero, 0);
    chk(!busy_o && !err_o, "R9 status after success", busy_o, 0);
  endtask

  task automatic t_short;
    bit all1;
    src[0] = 8'h81;
    run_load(1, 20, 0, 1'b0, 2000);
    chk(ok_o, "R6 ok with short image", ok_o, 1);
    chk(rx_byte(0) == 8'h81, "R3 short image byte", rx_byte(0), 8'h81);
    all1 = 1'b1;
    for (int j = 8; j < 20; j++) if (!rxbits[j]) all1 = 1'b0;
    chk(all1, "R7 ones after last byte", all1, 1);
  endtask

  task automatic t_crc_err;
    int r_snap;
    src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33; src[3] = 8'h44;
    run_load(4, 0, 10, 1'b0, 2000);
    chk(err_o, "R5 error on init low", err_o, 1);
    @(negedge clk);
    r_snap = rises;
    repeat (40) @(negedge clk);
    chk(rises == r_snap, "R5 clock stopped after error", rises, r_snap);
    chk(!busy_o && !cclk_o, "R5 idle after error", busy_o, 0);
  endtask

  task automatic t_init_timeout;
    src[0] = 8'hFF;
    run_load(1, 8, 0, 1'b1, 2000);
    chk(err_o, "R2 init timeout error", err_o, 1);
    chk(wait_n == PROG + INIT_TO, "R2 init timeout cycle", wait_n, PROG + INIT_TO);
    chk(rises == 0, "R2 no edge while init low", rises, 0);
    chk(prog_len == PROG, "R1 pulse on restart from error", prog_len, PROG);
    t_hold = 1'b0;
  endtask

  task automatic t_done_timeout;
    src[0] = 8'hC3;
    run_load(1, 0, 0, 1'b0, 3000);
    chk(err_o, "R8 done timeout error", err_o, 1);
    chk(rx_byte(0) == 8'hC3, "R8 data before timeout", rx_byte(0), 8'hC3);
  endtask

  task automatic t_mid_done;
    src[0] = 8'h5A; src[1] = 8'h96;
    run_load(2, 12, 0, 1'b0, 2000);
    chk(ok_o, "R6 ok with done inside a byte", ok_o, 1);
    chk(rx_byte(0) == 8'h5A, "R3 first byte", rx_byte(0), 8'h5A);
    chk(post_rises >= POSTC, "R6 startup edges mid byte", post_rises, POSTC);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_short();
    t_crc_err();
    t_init_timeout();
    t_done_timeout();
    t_mid_done();
    chk(ready_bad == 0, "R4 ready only while loading", ready_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule